// File: doc/BRIEF.md
# Divided-Clock Serial Peripheral Master

This block is a single-slave serial peripheral interface master. A one-cycle `start` pulse captures a parallel transmit word and a divider value. The block then runs one frame. It pulls the active-low select line low and shifts the transmit word out most-significant bit first. At the same time it collects a word from the data-in line in the same bit order. When the frame ends it pulses `done` for one cycle, and the received word is valid on `rx_word` in that cycle.

The serial clock is made from the system clock by a programmable divider. A divider value D gives a serial period of D+1 system cycles. The split between the high and low phases depends on whether D is even or odd. The serial clock rests high between frames. Data leaves on falling edges and is captured on rising edges. The first data bit appears on the data-out line when select falls. The first falling edge comes one full serial period later. After the final rising edge, the data-out driver is released and select is held low for one more high phase.

The block has no slave mode, no FIFOs and no multi-slave decode. The data-out line is presented as a value plus an output-enable, so the pad ring can build the tri-state buffer.

Top module: `spi_divclk_master`

## Requirements
- R1: After reset, and whenever no frame is active, `busy` is 0, `spi_sclk` is 1, `spi_ss_n` is 1 and `spi_mosi_oe` is 0.
- R2: A `start` pulse while idle makes `busy` 1 in the next cycle. In the cycle that `spi_ss_n` falls, `spi_mosi_oe` is 1 and `spi_mosi` carries bit WORD_W-1 of the captured word, while `spi_sclk` is still high.
- R3: The first falling edge of `spi_sclk` comes exactly D+1 system cycles after `spi_ss_n` falls, where D is the effective divider value.
- R4: Consecutive rising edges of `spi_sclk` within a frame are exactly D+1 system cycles apart.
- R5: For an even D, each high phase between edges lasts D/2+1 cycles and each low phase lasts D/2 cycles.
- R6: For an odd D, the high and low phases each last (D+1)/2 cycles.
- R7: A divider value of 0 produces the same timing as a value of 1, which is 1 cycle high and 1 cycle low.
- R8: Bit k of the word (k = WORD_W-1 down to 0) is on `spi_mosi` at the (WORD_W-k)-th rising edge. `spi_mosi` changes only in cycles where `spi_sclk` falls.
- R9: The value of `spi_miso` at each rising edge is captured, the first one as bit WORD_W-1. In the single cycle where `done` is 1, `rx_word` holds the captured word and `spi_ss_n` is already high.
- R10: `spi_ss_n` returns high exactly one high phase after the final rising edge of the frame.
- R11: `spi_mosi_oe` falls one system cycle after the final rising edge, and is never 1 while `spi_ss_n` is high.
- R12: A `start` pulse while `busy` is 1 is ignored. The running frame keeps its word and divider, and no further frame follows it.
- R13: Each frame has exactly WORD_W rising edges of `spi_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| tx_word | input | WORD_W | Word to transmit, captured on an accepted start |
| div | input | DIV_W | Divider value D, captured on an accepted start |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame has finished |
| rx_word | output | WORD_W | Last received word |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_mosi | output | 1 | Serial data out value |
| spi_mosi_oe | output | 1 | Output enable for the data-out driver |
| spi_miso | input | 1 | Serial data in |

## Verification
A phase counter loaded with the wrong length shows up at once as a wrong gap between two edges of `spi_sclk`, measured in system cycles at the next edge. A bad bit counter shows up at the end of the frame as the wrong number of rising edges, or as a select or output-enable release that comes at the wrong time. A shift register that slips by one position shows up when the frame closes, as a mismatch between the word the bench's slave model collected and the word it was sent, or between `rx_word` and the slave's word.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Frame sequencing states
    typedef enum logic [1:0] {
        SPIM_IDLE,
        SPIM_LEAD,
        SPIM_LOW,
        SPIM_HIGH
    } spim_state_e;

    // Which phase length the timer is loaded with
    typedef enum logic [1:0] {
        LEN_NONE,
        LEN_PERIOD,
        LEN_LOW,
        LEN_HIGH
    } spim_len_sel_e;

    // Commands from the sequencer to the data path
    typedef struct packed {
        logic load;    // capture transmit word
        logic shift;   // advance transmit register
        logic sample;  // capture one input bit
        logic commit;  // publish received word
    } spim_shift_cmd_t;

endpackage

// File: rtl/spim_phase_calc.sv
module spim_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] period_m1_o,
    output logic [DIV_W-1:0] high_m1_o,
    output logic [DIV_W-1:0] low_m1_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        eff         = (div_i == '0) ? ONE : div_i;
        half        = eff >> 1;
        period_m1_o = eff;
        // Odd: both phases (D+1)/2. Even: high D/2+1, low D/2.
        high_m1_o   = half;
        low_m1_o    = eff[0] ? half : (half - ONE);
    end
endmodule

// File: rtl/spim_phase_timer.sv
module spim_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DIV_W-1:0] val_i,
    output logic             expired_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spim_shift_unit.sv
module spim_shift_unit
    import spim_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  spim_shift_cmd_t   cmd_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_word_o
);
    logic [WORD_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [WORD_W-1:0] rx_word_q;
    logic [WORD_W-1:0] tx_next;
    logic [WORD_W-1:0] rx_next;

    generate
        if (WORD_W > 1) begin : g_wide
            assign tx_next = {tx_sh_q[WORD_W-2:0], 1'b0};
            assign rx_next = {rx_sh_q[WORD_W-2:0], miso_i};
        end else begin : g_single
            assign tx_next = 1'b0;
            assign rx_next = miso_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            rx_word_q <= '0;
        end else begin
            if (cmd_i.load) begin
                tx_sh_q <= tx_word_i;
            end else if (cmd_i.shift) begin
                tx_sh_q <= tx_next;
            end
            if (cmd_i.sample) begin
                rx_sh_q <= rx_next;
            end
            if (cmd_i.commit) begin
                rx_word_q <= rx_sh_q;
            end
        end
    end

    assign mosi_o    = tx_sh_q[WORD_W-1];
    assign rx_word_o = rx_word_q;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            expired_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            sclk_o,
    output logic            frame_o,
    output logic            oe_o,
    output spim_shift_cmd_t cmd_o,
    output spim_len_sel_e   len_sel_o
);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    spim_state_e      state_q;
    logic [BIT_W-1:0] bit_q;
    logic             sclk_q;
    logic             frame_q;
    logic             oe_q;
    logic             done_q;
    logic             last_bit;

    assign last_bit = (bit_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPIM_IDLE;
            bit_q   <= '0;
            sclk_q  <= 1'b1;
            frame_q <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SPIM_IDLE: begin
                    if (start_i) begin
                        state_q <= SPIM_LEAD;
                        frame_q <= 1'b1;
                        oe_q    <= 1'b1;
                        bit_q   <= '0;
                    end
                end
                SPIM_LEAD: begin
                    if (expired_i) begin
                        state_q <= SPIM_LOW;
                        sclk_q  <= 1'b0;
                    end
                end
                SPIM_LOW: begin
                    if (expired_i) begin
                        state_q <= SPIM_HIGH;
                        sclk_q  <= 1'b1;
                    end
                end
                SPIM_HIGH: begin
                    if (last_bit) begin
                        oe_q <= 1'b0;
                    end
                    if (expired_i) begin
                        if (last_bit) begin
                            state_q <= SPIM_IDLE;
                            frame_q <= 1'b0;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SPIM_LOW;
                            sclk_q  <= 1'b0;
                            bit_q   <= bit_q + BIT_W'(1);
                        end
                    end
                end
                default: state_q <= SPIM_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o     = '0;
        len_sel_o = LEN_NONE;
        unique case (state_q)
            SPIM_IDLE: begin
                if (start_i) begin
                    cmd_o.load = 1'b1;
                    len_sel_o  = LEN_PERIOD;
                end
            end
            SPIM_LEAD: begin
                if (expired_i) len_sel_o = LEN_LOW;
            end
            SPIM_LOW: begin
                if (expired_i) begin
                    cmd_o.sample = 1'b1;
                    len_sel_o    = LEN_HIGH;
                end
            end
            SPIM_HIGH: begin
                if (expired_i) begin
                    if (last_bit) begin
                        cmd_o.commit = 1'b1;
                    end else begin
                        cmd_o.shift = 1'b1;
                        len_sel_o   = LEN_LOW;
                    end
                end
            end
            default: ;
        endcase
    end

    assign busy_o  = (state_q != SPIM_IDLE);
    assign done_o  = done_q;
    assign sclk_o  = sclk_q;
    assign frame_o = frame_q;
    assign oe_o    = oe_q;
endmodule

// File: rtl/spi_divclk_master.sv
module spi_divclk_master
    import spim_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  div,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              spi_sclk,
    output logic              spi_ss_n,
    output logic              spi_mosi,
    output logic              spi_mosi_oe,
    input  logic              spi_miso
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_sel;
    logic [DIV_W-1:0] period_m1;
    logic [DIV_W-1:0] high_m1;
    logic [DIV_W-1:0] low_m1;
    logic [DIV_W-1:0] timer_val;
    logic             timer_load;
    logic             expired;
    logic             frame;
    spim_shift_cmd_t  cmd;
    spim_len_sel_e    len_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (!busy && start) begin
            div_q <= div;
        end
    end

    // Idle: use the live value so the lead phase is loaded on start
    assign div_sel = busy ? div_q : div;

    spim_phase_calc #(.DIV_W(DIV_W)) calc_i (
        .div_i       (div_sel),
        .period_m1_o (period_m1),
        .high_m1_o   (high_m1),
        .low_m1_o    (low_m1)
    );

    always_comb begin
        unique case (len_sel)
            LEN_PERIOD: timer_val = period_m1;
            LEN_LOW:    timer_val = low_m1;
            LEN_HIGH:   timer_val = high_m1;
            default:    timer_val = '0;
        endcase
    end
    assign timer_load = (len_sel != LEN_NONE);

    spim_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (timer_load),
        .val_i     (timer_val),
        .expired_o (expired)
    );

    spim_ctrl #(.WORD_W(WORD_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .expired_i (expired),
        .busy_o    (busy),
        .done_o    (done),
        .sclk_o    (spi_sclk),
        .frame_o   (frame),
        .oe_o      (spi_mosi_oe),
        .cmd_o     (cmd),
        .len_sel_o (len_sel)
    );

    spim_shift_unit #(.WORD_W(WORD_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .tx_word_i (tx_word),
        .miso_i    (spi_miso),
        .mosi_o    (spi_mosi),
        .rx_word_o (rx_word)
    );

    // Active-high frame inverted onto the pin
    assign spi_ss_n = ~frame;
endmodule

// File: rtl/spim_checker.sv
module spim_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic spi_sclk,
    input logic spi_ss_n,
    input logic spi_mosi,
    input logic spi_mosi_oe
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_sclk && spi_ss_n && !spi_mosi_oe));

    // R2
    frame_open_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_ss_n) |-> (spi_sclk && spi_mosi_oe && $past(start)));

    // R3
    clock_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_sclk |-> !spi_ss_n);

    // R8
    mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_mosi_oe && $past(spi_mosi_oe) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_closed_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (spi_ss_n && !busy));

    // R11
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        spi_mosi_oe |-> !spi_ss_n);
endmodule

bind spi_divclk_master spim_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .spi_sclk    (spi_sclk),
    .spi_ss_n    (spi_ss_n),
    .spi_mosi    (spi_mosi),
    .spi_mosi_oe (spi_mosi_oe)
);

// File: tb/spi_divclk_master_tb_top.sv
module spi_divclk_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int DIV_W      = 8;

    typedef struct {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] sw;
        int                dv;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [WORD_W-1:0] tx_word = '0;
    logic [DIV_W-1:0]  div = '0;
    logic              busy, done, spi_sclk, spi_ss_n, spi_mosi, spi_mosi_oe;
    logic [WORD_W-1:0] rx_word;
    logic              spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;

    item_t exp_q[$];
    item_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_divclk_master #(.WORD_W(WORD_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .div(div),
        .busy(busy), .done(done), .rx_word(rx_word),
        .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
        .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Phase lengths from the requirements (R5, R6, R7)
    function automatic int eff_div(input int dv);
        return (dv == 0) ? 1 : dv;
    endfunction
    function automatic int high_len(input int dv);
        int e = eff_div(dv);
        return (e % 2 == 0) ? (e / 2 + 1) : ((e + 1) / 2);
    endfunction
    function automatic int low_len(input int dv);
        int e = eff_div(dv);
        return (e % 2 == 0) ? (e / 2) : ((e + 1) / 2);
    endfunction
    function automatic string duty_req(input int dv);
        if (dv == 0) return "R7";
        return (dv % 2 == 0) ? "R5" : "R6";
    endfunction

    // Monitor and slave model
    longint cyc = 0;
    longint t_ss, t_fall, t_rise;
    int     rises, falls;
    logic [WORD_W-1:0] cap;
    bit     stab_ok, in_frame = 0;
    logic   p_sclk = 1'b1, p_ss = 1'b1, p_oe = 1'b0, p_mosi = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (p_ss && !spi_ss_n) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R12", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                end
                in_frame = 1; t_ss = cyc; rises = 0; falls = 0; cap = '0; stab_ok = 1;
                chk(spi_mosi == cur.tx[WORD_W-1] && spi_mosi_oe && spi_sclk, "R2",
                    {spi_mosi, spi_mosi_oe, spi_sclk}, {cur.tx[WORD_W-1], 2'b11});
                spi_miso <= cur.sw[WORD_W-1];
            end
            if (in_frame && p_sclk && !spi_sclk) begin
                if (falls == 0)
                    chk(cyc - t_ss == eff_div(cur.dv) + 1, (cur.dv == 0) ? "R7" : "R3",
                        cyc - t_ss, eff_div(cur.dv) + 1);
                else
                    chk(cyc - t_rise == high_len(cur.dv), duty_req(cur.dv),
                        cyc - t_rise, high_len(cur.dv));
                if (rises < WORD_W) spi_miso <= cur.sw[WORD_W-1-rises];
                falls++; t_fall = cyc;
            end
            if (in_frame && !p_sclk && spi_sclk) begin
                chk(cyc - t_fall == low_len(cur.dv), duty_req(cur.dv),
                    cyc - t_fall, low_len(cur.dv));
                if (rises > 0)
                    chk(cyc - t_rise == eff_div(cur.dv) + 1, "R4",
                        cyc - t_rise, eff_div(cur.dv) + 1);
                cap = {cap[WORD_W-2:0], spi_mosi};
                rises++; t_rise = cyc;
            end
            if (in_frame && spi_mosi_oe && p_oe && !(p_sclk && !spi_sclk) && spi_mosi != p_mosi)
                stab_ok = 0;
            if (in_frame && p_oe && !spi_mosi_oe)
                chk(cyc - t_rise == 1 && rises == WORD_W, "R11", cyc - t_rise, 1);
            if (in_frame && !p_ss && spi_ss_n) begin
                chk(cyc - t_rise == high_len(cur.dv), "R10", cyc - t_rise, high_len(cur.dv));
                chk(rises == WORD_W, "R13", rises, WORD_W);
                chk(cap == cur.tx, "R8", cap, cur.tx);
                chk(stab_ok, "R8", 0, 1);
                in_frame = 0;
            end
            if (done) begin
                chk(rx_word == cur.sw, "R9", rx_word, cur.sw);
                chk(spi_ss_n && !spi_mosi_oe, "R9", spi_ss_n, 1);
            end
            if (done && p_done) chk(0, "R9", 1, 0);
            p_sclk = spi_sclk; p_ss = spi_ss_n; p_oe = spi_mosi_oe;
            p_mosi = spi_mosi; p_done = done;
        end
    end

    // Driver: pushes the expected frame, then requests it
    task automatic run_frame(input logic [WORD_W-1:0] tx, input logic [WORD_W-1:0] sw,
                             input int dv, input bit poke);
        while (busy) @(negedge clk);
        exp_q.push_back('{tx: tx, sw: sw, dv: dv});
        tx_word = tx; div = DIV_W'(dv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2", busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            tx_word = ~tx; div = DIV_W'(dv + 3); start = 1'b1;  // R12: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (!done);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(spi_ss_n && !busy && exp_q.size() == 0, "R12", {spi_ss_n, busy}, 2'b10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(spi_sclk && spi_ss_n && !spi_mosi_oe && !busy && !done, "R1",
            {spi_sclk, spi_ss_n, spi_mosi_oe, busy, done}, 5'b11000);
        run_frame(16'hA5C3, 16'h3C5A, 4, 0);
        run_frame(16'h8001, 16'hF00F, 3, 0);
        run_frame(16'h1234, 16'hFFFF, 0, 0);
        run_frame(16'hFFFF, 16'h0000, 1, 0);
        run_frame(16'h0000, 16'h8000, 2, 0);
        run_frame(16'h6B2D, 16'h0001, 7, 1);
        run_frame(16'h0F0F, 16'hCAFE, 6, 0);
        run_frame(16'hBEEF, 16'h1357, 5, 1);
        repeat (3) @(negedge clk);
        // R1: back to idle
        chk(spi_sclk && spi_ss_n && !spi_mosi_oe && !busy && exp_q.size() == 0, "R1",
            {spi_sclk, spi_ss_n, spi_mosi_oe, busy}, 4'b1100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule